// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block holds the time of day and a calendar in ten byte-wide registers: seconds, minutes, hours, day of week, date, month and year, plus an alarm byte each for seconds, minutes and hours. A one-cycle `tick_1hz` strobe moves the clock forward by one second. The carry runs through the minutes, hours, weekday, date, month and year.

Three static mode inputs come from a control register elsewhere in the chip. `upd_en` lets ticks advance the clock. `bin_mode` picks how every field is coded. `hr24` picks the hour format. Software reads and writes the registers through a simple byte port; reads are combinational. Each time the clock advances, the block raises a one-cycle update strobe. An alarm pulse goes with that strobe when the new time matches the alarm bytes.

Top module: `rtc_calendar`

## Requirements
- R1: The register offsets are: 0 seconds, 1 seconds alarm, 2 minutes, 3 minutes alarm, 4 hours, 5 hours alarm, 6 day of week, 7 date, 8 month, 9 year.
  - A write to offsets 0–9 with `reg_wr`=1 is read back on `reg_rdata` from the cycle after the write edge.
  - Offsets 0Ah–0Fh read 00h, and writes to them change nothing.
- R2: Bit 7 of the seconds register cannot be written. It always reads 0.
- R3: With `upd_en`=1, each clock edge that samples `tick_1hz`=1 advances the time by one second. With `upd_en`=0, ticks are ignored and the time holds. A register write in the same cycle as a tick takes priority: the written value is stored and that tick is dropped.
- R4: With `bin_mode`=0, fields are packed BCD. Seconds and minutes run 00h–59h and carry upward after 59h; for example, seconds 09h become 10h.
- R5: With `bin_mode`=1, fields are plain binary. Seconds and minutes run 00h–3Bh, hours 00h–17h in 24-hour mode, date up to 1Fh, month up to 0Ch and year up to 63h.
- R6: With `hr24`=1, hours run 0–23. A rollover from 23:59:59 clears the time and carries into the day fields. The day of week runs 1–7 (1 = Sunday) and wraps from 7 to 1.
- R7: With `hr24`=0, the hours field holds 1–12 in bits 6:0, and bit 7 set means PM. The PM bit changes only on the step from 11 to 12.
  - In BCD: 11h becomes 92h, and 92h becomes 81h.
  - 91h becomes 12h and carries into the day fields.
  - 12h becomes 01h.
- R8: The date rolls over after the last day of the month:
  - 30 days for months 4, 6, 9 and 11; 31 days for the other months except February.
  - February has 29 days when the year is divisible by 4, and 28 days otherwise.
  - Month 12 wraps to 1 and carries into the year; year 99 wraps to 0.
- R9: `alarm_hit` is a one-cycle pulse in the same cycle as `uip`. It fires when each of the three alarm bytes equals its time byte (the hour comparison includes the PM bit) after the advance. An alarm byte with bits 7:6 = 11 (C0h–FFh) matches any value.
- R10: `uip` is high for exactly the one cycle after each clock edge that advanced the time, and low at all other times.
- R11: After reset, the day of week, date and month read 01h, all other registers read 00h, and `uip` and `alarm_hit` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1hz | input | 1 | One-cycle strobe, once per second |
| upd_en | input | 1 | 1 lets ticks advance the clock |
| bin_mode | input | 1 | 0 = BCD fields, 1 = binary fields |
| hr24 | input | 1 | 1 = 24-hour format, 0 = 12-hour with PM in bit 7 |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register offset |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| uip | output | 1 | One-cycle update indication |
| alarm_hit | output | 1 | One-cycle alarm match pulse |

## Verification
The advance is tried from times set just below each carry boundary, and the expected result at each boundary tells the following apart:
- A seconds value of 09h, which separates BCD stepping (10h) from binary stepping (0Ah).
- A full 23:59:59 rollover in both encodings.
- The four 12-hour transitions around noon and midnight, which expose a wrong PM toggle or a missing day carry.
- February in a leap and a non-leap year, plus a 30-day month and year end, which separate the month-length cases.

Alarm stimulus compares three situations:
- Wildcard bytes against exact bytes.
- A match against the second just after it.
- A mismatch in one field only.

Ticks sent while the clock is disabled, or together with a write, must produce no update strobe at all.

// File: rtl/rtcc_pkg.sv
package rtcc_pkg;

  localparam int BYTE_W   = 8;
  localparam int NUM_REGS = 10;

  localparam int IDX_SEC  = 0;
  localparam int IDX_ASEC = 1;
  localparam int IDX_MIN  = 2;
  localparam int IDX_AMIN = 3;
  localparam int IDX_HR   = 4;
  localparam int IDX_AHR  = 5;
  localparam int IDX_DOW  = 6;
  localparam int IDX_DATE = 7;
  localparam int IDX_MON  = 8;
  localparam int IDX_YR   = 9;

  typedef logic [BYTE_W-1:0] byte_t;

  typedef struct packed {
    byte_t sec;
    byte_t min;
    byte_t hr;
    byte_t dow;
    byte_t date;
    byte_t mon;
    byte_t yr;
  } tod_t;

  // packed BCD byte to binary value
  function automatic byte_t bcd_to_bin(input byte_t b);
    return byte_t'(b[7:4]) * byte_t'(10) + byte_t'(b[3:0]);
  endfunction

  // binary value (0..99) to packed BCD byte
  function automatic byte_t bin_to_bcd(input byte_t v);
    byte_t tens, ones;
    tens = v / byte_t'(10);
    ones = v % byte_t'(10);
    return {tens[3:0], ones[3:0]};
  endfunction

  function automatic byte_t field_decode(input byte_t b, input logic bin);
    return bin ? b : bcd_to_bin(b);
  endfunction

  function automatic byte_t field_encode(input byte_t v, input logic bin);
    return bin ? v : bin_to_bcd(v);
  endfunction

  // month and year are binary values here
  function automatic byte_t month_days(input byte_t mo, input byte_t yr);
    byte_t n;
    case (mo)
      8'd4, 8'd6, 8'd9, 8'd11: n = 8'd30;
      8'd2:                    n = (yr[1:0] == 2'b00) ? 8'd29 : 8'd28;
      default:                 n = 8'd31;
    endcase
    return n;
  endfunction

  // an alarm byte with both top bits set matches anything
  function automatic logic alarm_field_hit(input byte_t alm, input byte_t cur);
    return (alm[7:6] == 2'b11) || (alm == cur);
  endfunction

  function automatic byte_t reg_reset_val(input int idx);
    return (idx == IDX_DOW || idx == IDX_DATE || idx == IDX_MON) ? 8'h01 : 8'h00;
  endfunction

  function automatic byte_t reg_write_mask(input int idx);
    return (idx == IDX_SEC) ? 8'h7F : 8'hFF;
  endfunction

endpackage

// File: rtl/rtcc_next_time.sv
module rtcc_next_time
  import rtcc_pkg::*;
(
  input  tod_t cur,
  input  logic bin_mode,
  input  logic hr24,
  output tod_t nxt,
  output logic day_carry
);

  byte_t s, m, h, dw, d, mo, y, dim, hx;
  logic  pm, c_sec, c_min, c_hr, c_day, c_mon;

  always_comb begin
    s   = field_decode(cur.sec, bin_mode);
    m   = field_decode(cur.min, bin_mode);
    h   = hr24 ? field_decode(cur.hr, bin_mode)
               : field_decode({1'b0, cur.hr[6:0]}, bin_mode);
    pm  = cur.hr[7];
    dw  = field_decode(cur.dow, bin_mode);
    d   = field_decode(cur.date, bin_mode);
    mo  = field_decode(cur.mon, bin_mode);
    y   = field_decode(cur.yr, bin_mode);
    dim = month_days(mo, y);
    hx  = '0;
    nxt = cur;

    c_sec   = (s >= 8'd59);
    nxt.sec = c_sec ? 8'h00 : field_encode(s + 8'd1, bin_mode);

    c_min = c_sec && (m >= 8'd59);
    if (c_sec) nxt.min = (m >= 8'd59) ? 8'h00 : field_encode(m + 8'd1, bin_mode);

    c_hr = 1'b0;
    if (c_min) begin
      if (hr24) begin
        c_hr   = (h >= 8'd23);
        nxt.hr = c_hr ? 8'h00 : field_encode(h + 8'd1, bin_mode);
      end else if (h == 8'd11) begin
        hx     = field_encode(8'd12, bin_mode);
        nxt.hr = {~pm, hx[6:0]};
        c_hr   = pm;
      end else if (h >= 8'd12) begin
        nxt.hr = {pm, 7'd1};
      end else begin
        hx     = field_encode(h + 8'd1, bin_mode);
        nxt.hr = {pm, hx[6:0]};
      end
    end

    c_day = c_hr && (d >= dim);
    c_mon = c_day && (mo >= 8'd12);
    if (c_hr) begin
      nxt.dow  = (dw >= 8'd7) ? 8'h01 : field_encode(dw + 8'd1, bin_mode);
      nxt.date = c_day ? 8'h01 : field_encode(d + 8'd1, bin_mode);
    end
    if (c_day) nxt.mon = c_mon ? 8'h01 : field_encode(mo + 8'd1, bin_mode);
    if (c_mon) nxt.yr  = (y >= 8'd99) ? 8'h00 : field_encode(y + 8'd1, bin_mode);

    day_carry = c_hr;
  end

endmodule

// File: rtl/rtcc_alarm_match.sv
module rtcc_alarm_match
  import rtcc_pkg::*;
#(
  parameter int N_FIELDS = 3
) (
  input  byte_t alm   [N_FIELDS],
  input  byte_t cur   [N_FIELDS],
  output logic  match
);

  logic [N_FIELDS-1:0] hit;

  for (genvar gi = 0; gi < N_FIELDS; gi++) begin : g_field
    assign hit[gi] = alarm_field_hit(alm[gi], cur[gi]);
  end

  assign match = &hit;

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
  import rtcc_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic              upd_en,
  input  logic              bin_mode,
  input  logic              hr24,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              uip,
  output logic              alarm_hit
);

  localparam int N_ALM = 3;

  byte_t regs_q [NUM_REGS];
  byte_t nxt_b  [NUM_REGS];
  tod_t  cur_tod, nxt_tod;
  byte_t alm_v  [N_ALM];
  byte_t tim_v  [N_ALM];

  // named internal events
  logic  adv_fire, alm_match, day_carry;
  byte_t sec_q, min_q;
  logic  uip_q, alarm_q;

  assign adv_fire = tick_1hz && upd_en && !reg_wr;
  assign sec_q    = regs_q[IDX_SEC];
  assign min_q    = regs_q[IDX_MIN];

  assign cur_tod.sec  = regs_q[IDX_SEC];
  assign cur_tod.min  = regs_q[IDX_MIN];
  assign cur_tod.hr   = regs_q[IDX_HR];
  assign cur_tod.dow  = regs_q[IDX_DOW];
  assign cur_tod.date = regs_q[IDX_DATE];
  assign cur_tod.mon  = regs_q[IDX_MON];
  assign cur_tod.yr   = regs_q[IDX_YR];

  rtcc_next_time u_next (
    .cur       (cur_tod),
    .bin_mode  (bin_mode),
    .hr24      (hr24),
    .nxt       (nxt_tod),
    .day_carry (day_carry)
  );

  always_comb begin
    nxt_b[IDX_SEC]  = nxt_tod.sec;
    nxt_b[IDX_ASEC] = regs_q[IDX_ASEC];
    nxt_b[IDX_MIN]  = nxt_tod.min;
    nxt_b[IDX_AMIN] = regs_q[IDX_AMIN];
    nxt_b[IDX_HR]   = nxt_tod.hr;
    nxt_b[IDX_AHR]  = regs_q[IDX_AHR];
    nxt_b[IDX_DOW]  = nxt_tod.dow;
    nxt_b[IDX_DATE] = nxt_tod.date;
    nxt_b[IDX_MON]  = nxt_tod.mon;
    nxt_b[IDX_YR]   = nxt_tod.yr;
  end

  assign alm_v[0] = regs_q[IDX_ASEC];
  assign alm_v[1] = regs_q[IDX_AMIN];
  assign alm_v[2] = regs_q[IDX_AHR];
  assign tim_v[0] = nxt_tod.sec;
  assign tim_v[1] = nxt_tod.min;
  assign tim_v[2] = nxt_tod.hr;

  rtcc_alarm_match #(.N_FIELDS(N_ALM)) u_alarm (
    .alm   (alm_v),
    .cur   (tim_v),
    .match (alm_match)
  );

  // register file: a write wins over an advance in the same cycle
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (!rst_n)
        regs_q[i] <= reg_reset_val(i);
      else if (reg_wr && reg_addr == ADDR_W'(i))
        regs_q[i] <= reg_wdata & reg_write_mask(i);
      else if (adv_fire)
        regs_q[i] <= nxt_b[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      uip_q   <= 1'b0;
      alarm_q <= 1'b0;
    end else begin
      uip_q   <= adv_fire;
      alarm_q <= adv_fire && alm_match;
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (reg_addr == ADDR_W'(i)) reg_rdata = regs_q[i];
  end

  assign uip       = uip_q;
  assign alarm_hit = alarm_q;

endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_en,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [7:0]        reg_wdata,
  input logic              uip,
  input logic              alarm_hit,
  input logic              adv_fire,
  input logic [7:0]        sec_q,
  input logic [7:0]        min_q
);

  // R10
  adv_sets_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv_fire |=> uip);

  // R10
  no_spurious_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_fire |=> !uip);

  // R9
  alarm_with_uip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_hit |-> uip);

  // R2
  sec_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_q[7] == 1'b0);

  // R3
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_en && !reg_wr) |=> ($stable(sec_q) && $stable(min_q)));

  // R3
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !uip);

  // R1
  write_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(2)) |=> (min_q == $past(reg_wdata)));

endmodule

bind rtc_calendar rtc_calendar_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .upd_en    (upd_en),
  .reg_wr    (reg_wr),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .uip       (uip),
  .alarm_hit (alarm_hit),
  .adv_fire  (adv_fire),
  .sec_q     (sec_q),
  .min_q     (min_q)
);

// File: tb/rtc_calendar_tb_top.sv
`timescale 1ns/1ps
module rtc_calendar_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_1hz = 1'b0;
  logic       upd_en = 1'b1;
  logic       bin_mode = 1'b0;
  logic       hr24 = 1'b1;
  logic       reg_wr = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       uip, alarm_hit;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  typedef struct {
    bit    alarm;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  rtc_calendar dut_i (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .upd_en(upd_en),
    .bin_mode(bin_mode), .hr24(hr24), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .uip(uip), .alarm_hit(alarm_hit)
  );

  // monitor: every update strobe must match a queued expectation (R10, R9)
  always @(negedge clk) begin
    if (rst_n) begin
      if (uip) begin
        n_chk++;
        if (exp_q.size() == 0) begin
          n_fail++;
          $display("FAIL R10: uip=1 expected=0 (no advance was due)");
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (alarm_hit !== e.alarm) begin
            n_fail++;
            $display("FAIL %s: alarm_hit=%0b expected=%0b", e.tag, alarm_hit, e.alarm);
          end
        end
      end else if (alarm_hit) begin
        n_chk++;
        n_fail++;
        $display("FAIL R9: alarm_hit=1 without uip, expected 0");
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk_rd(input logic [3:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    #1;
    n_chk++;
    if (reg_rdata !== e) begin
      n_fail++;
      $display("FAIL %s: reg[%0h]=%02h expected=%02h", tag, a, reg_rdata, e);
    end
  endtask

  // driver: pulse one tick and queue the expected result
  task automatic tick_exp(input bit alarm, input string tag);
    exp_t e;
    e.alarm = alarm; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic tick_none();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(4'h4, h); wr(4'h2, m); wr(4'h0, s);
  endtask

  task automatic set_date(input logic [7:0] dw, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
    wr(4'h6, dw); wr(4'h7, dt); wr(4'h8, mo); wr(4'h9, yr);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    chk_rd(4'h0, 8'h00, "R11"); chk_rd(4'h2, 8'h00, "R11"); chk_rd(4'h4, 8'h00, "R11");
    chk_rd(4'h6, 8'h01, "R11"); chk_rd(4'h7, 8'h01, "R11"); chk_rd(4'h8, 8'h01, "R11");
    chk_rd(4'h9, 8'h00, "R11"); chk_rd(4'h5, 8'h00, "R11");
    n_chk++;
    if (uip !== 1'b0 || alarm_hit !== 1'b0) begin
      n_fail++;
      $display("FAIL R11: uip=%0b alarm_hit=%0b expected=0 0", uip, alarm_hit);
    end

    // R1 map and unused offsets
    wr(4'h5, 8'h17); chk_rd(4'h5, 8'h17, "R1 hours alarm");
    wr(4'h3, 8'h42); chk_rd(4'h3, 8'h42, "R1 minutes alarm");
    wr(4'hA, 8'h55); chk_rd(4'hA, 8'h00, "R1 offset 0Ah");
    wr(4'hF, 8'hAA); chk_rd(4'hF, 8'h00, "R1 offset 0Fh");
    chk_rd(4'h3, 8'h42, "R1 untouched by 0Fh write");

    // R2 read-only top bit of seconds
    wr(4'h0, 8'hFF); chk_rd(4'h0, 8'h7F, "R2");

    // clear alarms to exact values that will not match
    wr(4'h1, 8'h77); wr(4'h3, 8'h77); wr(4'h5, 8'h77);

    // R4 BCD stepping
    set_time(8'h00, 8'h09, 8'h09);
    tick_exp(0, "R4"); chk_rd(4'h0, 8'h10, "R4 09->10");
    set_time(8'h00, 8'h09, 8'h59);
    tick_exp(0, "R4"); chk_rd(4'h0, 8'h00, "R4 sec wrap"); chk_rd(4'h2, 8'h10, "R4 min carry");

    // R6 24h day rollover, weekday wrap
    set_date(8'h07, 8'h15, 8'h06, 8'h25);
    set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R6");
    chk_rd(4'h4, 8'h00, "R6 hours"); chk_rd(4'h2, 8'h00, "R6 min");
    chk_rd(4'h6, 8'h01, "R6 dow 7->1"); chk_rd(4'h7, 8'h16, "R6 date");
    chk_rd(4'h8, 8'h06, "R6 month held");

    // R8 month lengths
    set_date(8'h02, 8'h30, 8'h04, 8'h25); set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R8"); chk_rd(4'h7, 8'h01, "R8 Apr30 date"); chk_rd(4'h8, 8'h05, "R8 Apr30 month");
    set_date(8'h02, 8'h30, 8'h05, 8'h25); set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R8"); chk_rd(4'h7, 8'h31, "R8 May30->31");
    set_date(8'h02, 8'h28, 8'h02, 8'h24); set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R8"); chk_rd(4'h7, 8'h29, "R8 leap Feb28->29");
    set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R8"); chk_rd(4'h7, 8'h01, "R8 leap Feb29 date"); chk_rd(4'h8, 8'h03, "R8 leap month");
    set_date(8'h02, 8'h28, 8'h02, 8'h23); set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R8"); chk_rd(4'h7, 8'h01, "R8 nonleap date"); chk_rd(4'h8, 8'h03, "R8 nonleap month");
    set_date(8'h02, 8'h31, 8'h12, 8'h99); set_time(8'h23, 8'h59, 8'h59);
    tick_exp(0, "R8");
    chk_rd(4'h7, 8'h01, "R8 year end date"); chk_rd(4'h8, 8'h01, "R8 year end month");
    chk_rd(4'h9, 8'h00, "R8 year 99->00");

    // R5 binary encoding
    bin_mode = 1'b1;
    set_time(8'h00, 8'h00, 8'h09);
    tick_exp(0, "R5"); chk_rd(4'h0, 8'h0A, "R5 09->0A");
    set_date(8'h03, 8'h1F, 8'h0C, 8'h63); set_time(8'h17, 8'h3B, 8'h3B);
    tick_exp(0, "R5");
    chk_rd(4'h0, 8'h00, "R5 sec"); chk_rd(4'h4, 8'h00, "R5 hours");
    chk_rd(4'h7, 8'h01, "R5 date"); chk_rd(4'h8, 8'h01, "R5 month"); chk_rd(4'h9, 8'h00, "R5 year");
    chk_rd(4'h6, 8'h04, "R5 dow");
    bin_mode = 1'b0;

    // R7 12-hour sequence
    hr24 = 1'b0;
    set_date(8'h01, 8'h05, 8'h06, 8'h25);
    set_time(8'h11, 8'h59, 8'h59);
    tick_exp(0, "R7"); chk_rd(4'h4, 8'h92, "R7 11AM->12PM");
    set_time(8'h92, 8'h59, 8'h59);
    tick_exp(0, "R7"); chk_rd(4'h4, 8'h81, "R7 12PM->1PM");
    set_time(8'h91, 8'h59, 8'h59);
    tick_exp(0, "R7"); chk_rd(4'h4, 8'h12, "R7 11PM->12AM"); chk_rd(4'h7, 8'h06, "R7 day carry");
    set_time(8'h12, 8'h59, 8'h59);
    tick_exp(0, "R7"); chk_rd(4'h4, 8'h01, "R7 12AM->1AM"); chk_rd(4'h7, 8'h06, "R7 no carry");
    hr24 = 1'b1;

    // R9 alarm
    wr(4'h1, 8'h05); wr(4'h3, 8'hC5); wr(4'h5, 8'hFF);
    set_time(8'h00, 8'h00, 8'h04);
    tick_exp(1, "R9 wildcard match");
    tick_exp(0, "R9 next second");
    wr(4'h3, 8'h30);
    set_time(8'h00, 8'h00, 8'h04);
    tick_exp(0, "R9 minute mismatch");
    wr(4'h3, 8'h00); wr(4'h5, 8'h00);
    set_time(8'h00, 8'h00, 8'h04);
    tick_exp(1, "R9 exact match");

    // R3 disable and write priority
    wr(4'h1, 8'h77);
    set_time(8'h00, 8'h00, 8'h20);
    upd_en = 1'b0;
    tick_none(); tick_none();
    chk_rd(4'h0, 8'h20, "R3 frozen");
    upd_en = 1'b1;
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = 8'h30; tick_1hz = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; tick_1hz = 1'b0;
    chk_rd(4'h0, 8'h30, "R3 write wins");
    tick_exp(0, "R3"); chk_rd(4'h0, 8'h31, "R3 resumes");

    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_fail++;
      $display("FAIL R10: %0d updates missing, expected 0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end

endmodule